// File: doc/BRIEF.md
# Page Access Permission Fault Checker

This block sits at the end of an address-translation walk. It takes the flags that the walk found in the directory entry and, for small pages, in the leaf entry. It also takes the rights of the level above the directory, the leaf protection key and the current control state. From these it decides whether a user or supervisor read, write or instruction fetch must fault, and it builds the page-fault error code.

The caller raises `req_valid` for one cycle with all inputs stable. The verdict appears in registers on the next cycle and stays there until the next request. Walking the tables and delivering the exception are left to the surrounding logic.

A fetch that is also a write is not a real access. The block flags such a request as illegal instead of judging it.

Top module: `pgperm_checker`

## Requirements
- R1: After reset `fault_q`, `err_q` and `illegal_q` are 0. Inputs present with `req_valid` in one cycle are judged, and the result is visible after the next rising edge. Without a request the outputs hold their values. When there is no fault, `err_q` is zero.
- R2: The error code layout is bit 0 present, bit 1 write, bit 2 user, bit 3 reserved-bit violation, bit 4 instruction fetch, bit 5 protection key. On a fault, bit 1 copies `acc_write` and bit 2 copies `acc_user`.
- R3: If the directory entry is absent, or the page is small and the leaf entry is absent, the access faults with bits 0 and 3 clear. The directory entry is judged before the leaf entry.
- R4: A present entry with a reserved-bit violation faults with bits 0 and 3 set. The violations are:
  - either bit of its `*_rsvd` pair is set (address bits 51 and 36);
  - on a large-page directory entry only, `dir_bit13` is set;
  - its no-execute flag is set while `nx_en` is 0.
- R5: A write to a page that is not writable faults for a user access. It faults for a supervisor access only when `wp_en` is 1.
- R6: A page is writable only if `upper_writable`, `dir_writable` and, for small pages, `leaf_writable` are all 1.
- R7: A user access to a page whose combined user flag is 0 faults.
- R8: A fetch from a page whose directory or leaf no-execute flag is set faults.
- R9: With `smep_en` set, a supervisor fetch from a user page faults.
- R10: With `pke_en` set, a user-page data access (not a fetch) faults with bit 5 set when `pkru` bit 2k is 1, where k is `leaf_key`. Fetches, supervisor pages and `pke_en`=0 are never key-checked.
- R11: With `pke_en` set, a user-page write faults with bit 5 set when `pkru` bit 2k+1 is 1. The exception is a supervisor write with `wp_en` clear, which this check does not block.
- R12: Bit 4 is reported only when `nx_en` or `smep_en` is 1. Otherwise it reads 0 even for a faulting fetch.
- R13: A request with both `acc_fetch` and `acc_write` set gives `illegal_q`=1 with `fault_q`=0 and `err_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, samples all inputs |
| acc_user | input | 1 | Access made at user privilege |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| upper_writable | input | 1 | Writable right of the level above the directory |
| dir_present | input | 1 | Directory entry present |
| dir_writable | input | 1 | Directory entry writable |
| dir_user | input | 1 | Directory entry user-accessible |
| dir_nx | input | 1 | Directory entry no-execute flag |
| dir_large | input | 1 | Directory entry maps a large page (no leaf) |
| dir_rsvd | input | 2 | Directory address bits 51 and 36 |
| dir_bit13 | input | 1 | Directory bit 13 (reserved for large pages) |
| leaf_present | input | 1 | Leaf entry present |
| leaf_writable | input | 1 | Leaf entry writable |
| leaf_user | input | 1 | Leaf entry user-accessible |
| leaf_nx | input | 1 | Leaf entry no-execute flag |
| leaf_rsvd | input | 2 | Leaf address bits 51 and 36 |
| leaf_key | input | PKEY_W | Protection key of the final entry |
| nx_en | input | 1 | No-execute enable |
| wp_en | input | 1 | Supervisor write protection enable |
| smep_en | input | 1 | Supervisor execution prevention enable |
| pke_en | input | 1 | Protection-key checking enable |
| pkru | input | 2*2^PKEY_W | Key rights: bit 2k access-disable, bit 2k+1 write-disable |
| fault_q | output | 1 | Registered fault verdict |
| err_q | output | 6 | Registered error code |
| illegal_q | output | 1 | Registered illegal-request flag |

## Verification
Some cases need several unrelated inputs aligned at once. A key write-disable must meet a supervisor write with `wp_en` clear on a user page. Bit 4 must be masked while a fetch faults on another ground, such as an absent entry. A reserved no-execute flag must appear on the leaf while the directory is clean. Random stimulus rarely aligns all of these, so directed cases set each one up from a fully permissive baseline. Random traffic biased toward present, clean entries then covers the mixed combinations and is checked against a bench model.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
    localparam int ERR_W   = 6;
    localparam int EB_PRES = 0;
    localparam int EB_WR   = 1;
    localparam int EB_USR  = 2;
    localparam int EB_RSVD = 3;
    localparam int EB_FETCH = 4;
    localparam int EB_KEY  = 5;

    typedef struct packed {
        logic             illegal;
        logic             fault;
        logic [ERR_W-1:0] err;
    } verdict_t;
endpackage

// File: rtl/pgperm_entry_chk.sv
module pgperm_entry_chk #(
    parameter bit CHK_BIT13 = 1'b0
) (
    input  logic       present,
    input  logic [1:0] rsvd,
    input  logic       bit13,
    input  logic       nx,
    input  logic       nx_en,
    output logic       absent,
    output logic       rsvd_hit
);
    logic b13_hit;

    generate
        if (CHK_BIT13) begin : g_b13
            assign b13_hit = bit13;
        end else begin : g_nob13
            assign b13_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        absent   = !present;
        rsvd_hit = present && ((|rsvd) || b13_hit || (nx && !nx_en));
    end
endmodule

// File: rtl/pgperm_key_chk.sv
module pgperm_key_chk #(
    parameter int PKEY_W = 4,
    localparam int NKEYS = 1 << PKEY_W,
    localparam int RIGHTS_W = 2 * NKEYS
) (
    input  logic [PKEY_W-1:0]   key,
    input  logic [RIGHTS_W-1:0] rights,
    output logic                acc_dis,
    output logic                wr_dis
);
    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        assign ad_vec[k] = rights[2*k];
        assign wd_vec[k] = rights[2*k+1];
    end

    assign acc_dis = ad_vec[key];
    assign wr_dis  = wd_vec[key];
endmodule

// File: rtl/pgperm_checker.sv
module pgperm_checker
    import pgperm_pkg::*;
#(
    parameter int PKEY_W = 4,
    localparam int NKEYS = 1 << PKEY_W,
    localparam int RIGHTS_W = 2 * NKEYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                acc_user,
    input  logic                acc_write,
    input  logic                acc_fetch,
    input  logic                upper_writable,
    input  logic                dir_present,
    input  logic                dir_writable,
    input  logic                dir_user,
    input  logic                dir_nx,
    input  logic                dir_large,
    input  logic [1:0]          dir_rsvd,
    input  logic                dir_bit13,
    input  logic                leaf_present,
    input  logic                leaf_writable,
    input  logic                leaf_user,
    input  logic                leaf_nx,
    input  logic [1:0]          leaf_rsvd,
    input  logic [PKEY_W-1:0]   leaf_key,
    input  logic                nx_en,
    input  logic                wp_en,
    input  logic                smep_en,
    input  logic                pke_en,
    input  logic [RIGHTS_W-1:0] pkru,
    output logic                fault_q,
    output logic [ERR_W-1:0]    err_q,
    output logic                illegal_q
);
    verdict_t v_d, v_q;

    logic dir_absent, dir_rsvd_hit, leaf_absent, leaf_rsvd_hit;
    logic key_ad, key_wd;

    pgperm_entry_chk #(.CHK_BIT13(1'b1)) u_dir_chk (
        .present (dir_present),
        .rsvd    (dir_rsvd),
        .bit13   (dir_bit13 & dir_large),
        .nx      (dir_nx),
        .nx_en   (nx_en),
        .absent  (dir_absent),
        .rsvd_hit(dir_rsvd_hit)
    );

    pgperm_entry_chk #(.CHK_BIT13(1'b0)) u_leaf_chk (
        .present (leaf_present),
        .rsvd    (leaf_rsvd),
        .bit13   (1'b0),
        .nx      (leaf_nx),
        .nx_en   (nx_en),
        .absent  (leaf_absent),
        .rsvd_hit(leaf_rsvd_hit)
    );

    pgperm_key_chk #(.PKEY_W(PKEY_W)) u_key_chk (
        .key    (leaf_key),
        .rights (pkru),
        .acc_dis(key_ad),
        .wr_dis (key_wd)
    );

    always_comb begin
        logic [ERR_W-1:0] code;
        logic flt, can_w, can_u, can_x, sup_wr_ok, use_leaf;

        v_d = v_q;
        code = '0;
        code[EB_PRES]  = 1'b1;
        code[EB_WR]    = acc_write;
        code[EB_USR]   = acc_user;
        code[EB_FETCH] = acc_fetch;
        flt = 1'b0;

        use_leaf  = !dir_large;
        can_w     = upper_writable && dir_writable && (!use_leaf || leaf_writable);
        can_u     = dir_user && (!use_leaf || leaf_user);
        can_x     = !dir_nx && (!use_leaf || !leaf_nx);
        sup_wr_ok = !wp_en && !acc_user;

        if (dir_absent) begin
            flt = 1'b1;
            code[EB_PRES] = 1'b0;
        end else if (dir_rsvd_hit) begin
            flt = 1'b1;
            code[EB_RSVD] = 1'b1;
        end else if (use_leaf && leaf_absent) begin
            flt = 1'b1;
            code[EB_PRES] = 1'b0;
        end else if (use_leaf && leaf_rsvd_hit) begin
            flt = 1'b1;
            code[EB_RSVD] = 1'b1;
        end else begin
            if (acc_user && !can_u)                 flt = 1'b1;
            if (acc_write && !can_w && !sup_wr_ok)  flt = 1'b1;
            if (acc_fetch && !can_x)                flt = 1'b1;
            if (acc_fetch && !acc_user && can_u && smep_en) flt = 1'b1;
            if (can_u && !acc_fetch && pke_en) begin
                if (key_ad) begin
                    flt = 1'b1;
                    code[EB_KEY] = 1'b1;
                end else if (acc_write && key_wd && !sup_wr_ok) begin
                    flt = 1'b1;
                    code[EB_KEY] = 1'b1;
                end
            end
        end

        if (!nx_en && !smep_en) code[EB_FETCH] = 1'b0;

        if (req_valid) begin
            if (acc_fetch && acc_write) begin
                v_d.illegal = 1'b1;
                v_d.fault   = 1'b0;
                v_d.err     = '0;
            end else begin
                v_d.illegal = 1'b0;
                v_d.fault   = flt;
                v_d.err     = flt ? code : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign fault_q   = v_q.fault;
    assign err_q     = v_q.err;
    assign illegal_q = v_q.illegal;
endmodule

// File: rtl/pgperm_checker_sva.sv
module pgperm_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       acc_write,
    input logic       acc_fetch,
    input logic       dir_present,
    input logic       nx_en,
    input logic       smep_en,
    input logic       fault_q,
    input logic [5:0] err_q,
    input logic       illegal_q
);
    assert_quiet_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_q |-> (err_q == 6'd0));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(fault_q) && $stable(err_q) && $stable(illegal_q)));

    assert_dir_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dir_present && !(acc_fetch && acc_write))
        |=> (fault_q && !err_q[0] && !err_q[3]));

    assert_key_not_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q[5] |-> (fault_q && !err_q[4] && !err_q[3]));

    assert_fetch_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !nx_en && !smep_en) |=> !err_q[4]);

    assert_illegal_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_fetch && acc_write) |=> (illegal_q && !fault_q));

    assert_illegal_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (err_q == 6'd0));
endmodule

bind pgperm_checker pgperm_checker_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acc_write  (acc_write),
    .acc_fetch  (acc_fetch),
    .dir_present(dir_present),
    .nx_en      (nx_en),
    .smep_en    (smep_en),
    .fault_q    (fault_q),
    .err_q      (err_q),
    .illegal_q  (illegal_q)
);

// File: tb/sim_pgperm_checker.sv
module sim_pgperm_checker;
    localparam int PKEY_W = 4;
    localparam int RW = 2 * (1 << PKEY_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic acc_user, acc_write, acc_fetch, upper_writable;
    logic dir_present, dir_writable, dir_user, dir_nx, dir_large, dir_bit13;
    logic [1:0] dir_rsvd, leaf_rsvd;
    logic leaf_present, leaf_writable, leaf_user, leaf_nx;
    logic [PKEY_W-1:0] leaf_key;
    logic nx_en, wp_en, smep_en, pke_en;
    logic [RW-1:0] pkru;
    logic fault_q, illegal_q;
    logic [5:0] err_q;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pgperm_checker #(.PKEY_W(PKEY_W)) u0 (.*);

    function automatic logic [7:0] model();
        logic [5:0] e;
        logic f, dres, lres, w, u, x, kw;
        if (acc_fetch && acc_write) return 8'b1000_0000;
        e = {1'b0, acc_fetch, 1'b0, acc_user, acc_write, 1'b1};
        f = 1'b0;
        dres = (dir_rsvd != 0) || (dir_large && dir_bit13) || (dir_nx && !nx_en);
        lres = (leaf_rsvd != 0) || (leaf_nx && !nx_en);
        if (!dir_present) begin f = 1; e[0] = 0; end
        else if (dres) begin f = 1; e[3] = 1; end
        else if (!dir_large && !leaf_present) begin f = 1; e[0] = 0; end
        else if (!dir_large && lres) begin f = 1; e[3] = 1; end
        else begin
            w = upper_writable & dir_writable & (dir_large | leaf_writable);
            u = dir_user & (dir_large | leaf_user);
            x = !dir_nx & (dir_large | !leaf_nx);
            kw = !wp_en && !acc_user;
            if (acc_user && !u) f = 1;
            if (acc_write && !w && !kw) f = 1;
            if (acc_fetch && !x) f = 1;
            if (acc_fetch && u && !acc_user && smep_en) f = 1;
            if (u && !acc_fetch && pke_en) begin
                if (pkru[2*leaf_key]) begin f = 1; e[5] = 1; end
                else if (acc_write && pkru[2*leaf_key+1] && !kw) begin f = 1; e[5] = 1; end
            end
        end
        if (!nx_en && !smep_en) e[4] = 0;
        return {1'b0, f, f ? e : 6'd0};
    endfunction

    task automatic expect_out(input string tag, input logic ei, input logic ef, input logic [5:0] ee);
        n_chk++;
        if (illegal_q !== ei || fault_q !== ef || err_q !== ee) begin
            n_bad++;
            $display("FAIL %s: got ill=%b flt=%b err=%b expected ill=%b flt=%b err=%b",
                     tag, illegal_q, fault_q, err_q, ei, ef, ee);
        end
    endtask

    task automatic run(input string tag, input logic ei, input logic ef, input logic [5:0] ee);
        @(negedge clk) req_valid = 1'b1;
        @(negedge clk) req_valid = 1'b0;
        expect_out(tag, ei, ef, ee);
    endtask

    task automatic base();
        acc_user = 0; acc_write = 0; acc_fetch = 0; upper_writable = 1;
        dir_present = 1; dir_writable = 1; dir_user = 1; dir_nx = 0; dir_large = 0;
        dir_rsvd = 0; dir_bit13 = 0;
        leaf_present = 1; leaf_writable = 1; leaf_user = 1; leaf_nx = 0; leaf_rsvd = 0;
        leaf_key = 4'd1; nx_en = 1; wp_en = 1; smep_en = 0; pke_en = 0; pkru = '0;
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] m;
        void'($urandom(32'h5eed_0042));
        base();
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 0, 0, 6'd0);
        rst_n = 1'b1;

        run("R1 clean read", 0, 0, 6'd0);
        dir_present = 0; run("R3 dir absent", 0, 1, 6'b000000);
        base(); leaf_present = 0; acc_user = 1; acc_write = 1;
        run("R3 leaf absent, R2 bits", 0, 1, 6'b000110);
        base(); dir_present = 0; leaf_rsvd = 2'b01; run("R3 dir first", 0, 1, 6'b000000);
        acc_user = 1; @(negedge clk);
        expect_out("R1 hold w/o strobe", 0, 1, 6'b000000);
        base(); dir_large = 1; dir_bit13 = 1; run("R4 bit13 large", 0, 1, 6'b001001);
        base(); dir_bit13 = 1; run("R4 bit13 small ignored", 0, 0, 6'd0);
        base(); leaf_nx = 1; nx_en = 0; run("R4 nx reserved", 0, 1, 6'b001001);
        base(); dir_rsvd = 2'b10; leaf_present = 0; run("R4 dir rsvd", 0, 1, 6'b001001);
        base(); leaf_writable = 0; acc_write = 1; wp_en = 0; run("R5 sup override", 0, 0, 6'd0);
        wp_en = 1; run("R5 sup wp", 0, 1, 6'b000011);
        wp_en = 0; acc_user = 1; run("R5 user ro", 0, 1, 6'b000111);
        base(); upper_writable = 0; acc_write = 1; run("R6 upper ro", 0, 1, 6'b000011);
        base(); dir_large = 1; leaf_writable = 0; acc_write = 1; run("R6 large skips leaf", 0, 0, 6'd0);
        base(); leaf_user = 0; acc_user = 1; run("R7 user on sup", 0, 1, 6'b000101);
        base(); dir_nx = 1; acc_fetch = 1; run("R8 fetch nx", 0, 1, 6'b010001);
        base(); smep_en = 1; acc_fetch = 1; run("R9 smep", 0, 1, 6'b010001);
        leaf_user = 0; run("R9 smep sup page", 0, 0, 6'd0);
        base(); pke_en = 1; pkru[2] = 1; acc_user = 1; run("R10 key ad", 0, 1, 6'b100101);
        acc_user = 0; run("R10 key ad sup access", 0, 1, 6'b100001);
        acc_fetch = 1; run("R10 key skip fetch", 0, 0, 6'd0);
        acc_fetch = 0; pke_en = 0; run("R10 key off", 0, 0, 6'd0);
        pke_en = 1; leaf_user = 0; run("R10 key sup page", 0, 0, 6'd0);
        base(); pke_en = 1; pkru[3] = 1; acc_write = 1; acc_user = 1;
        run("R11 key wd user", 0, 1, 6'b100111);
        acc_user = 0; wp_en = 0; run("R11 wd sup override", 0, 0, 6'd0);
        wp_en = 1; run("R11 wd sup wp", 0, 1, 6'b100011);
        acc_write = 0; run("R11 wd read ok", 0, 0, 6'd0);
        base(); dir_present = 0; acc_fetch = 1; nx_en = 0; run("R12 fetch hidden", 0, 1, 6'b000000);
        smep_en = 1; run("R12 fetch shown", 0, 1, 6'b010000);
        base(); acc_fetch = 1; acc_write = 1; run("R13 illegal", 1, 0, 6'd0);

        for (int i = 0; i < 600; i++) begin
            acc_user = $urandom % 2; acc_write = $urandom % 2; acc_fetch = ($urandom % 3) == 0;
            upper_writable = ($urandom % 4) != 0;
            dir_present = ($urandom % 8) != 0; dir_writable = $urandom % 2;
            dir_user = ($urandom % 4) != 0; dir_nx = ($urandom % 4) == 0;
            dir_large = $urandom % 2; dir_rsvd = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            dir_bit13 = ($urandom % 8) == 0;
            leaf_present = ($urandom % 8) != 0; leaf_writable = $urandom % 2;
            leaf_user = ($urandom % 4) != 0; leaf_nx = ($urandom % 4) == 0;
            leaf_rsvd = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            leaf_key = 4'($urandom); nx_en = $urandom % 2; wp_en = $urandom % 2;
            smep_en = $urandom % 2; pke_en = $urandom % 2; pkru = RW'($urandom);
            m = model();
            run("R2 random", m[7], m[6], m[5:0]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule